// File: doc/BRIEF.md
# Gear-Selectable Clock Divider

This block turns a free-running oscillator into the internal operating clock. A source bit picks the oscillator itself or half of it, giving a "source period" of one or two oscillator cycles. A gear code then sets how many source periods make up one output period: one, two, four or eight. The output duty cycle is not 50%. Each output period ends with a low phase that lasts half a source period, and the output is high for the rest of the period. When the oscillator is used directly, that low phase is half an oscillator cycle. The output is therefore built from two levels held in registers for each oscillator cycle: one for the high half and one for the low half. The oscillator then chooses between them.

Software writes the source bit and the gear code through a one-cycle write strobe that is synchronous to the oscillator. The value is held as a pending setting and only loaded at the boundary of an output period. Because of this, a change never cuts a pulse short. A three-state machine walks through each output period. PH_HIGH covers the cycles that are high for the whole cycle. PH_EDGE is a closing cycle that is high then low and is used with the direct source. PH_LOW is a closing cycle that is low for the whole cycle and is used with the halved source. The transitions are:
- HIGH_COUNT: PH_HIGH to PH_HIGH while more high cycles remain.
- HIGH_TO_EDGE / HIGH_TO_LOW: PH_HIGH to the closing state that matches the active source.
- RELOAD_HIGH: a closing state to PH_HIGH when the newly loaded period is longer than one cycle.
- RELOAD_EDGE: a closing state to PH_EDGE when the new period is a single cycle.

Reset puts the machine in PH_LOW.

Top module: `gear_clk_divider`

## Requirements
- R1: The gear code sets how many source periods make up one output period: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 8.
- R2: A source bit of 0 makes the source period one oscillator cycle. A source bit of 1 makes it two oscillator cycles.
- R3: Each output period ends with a low phase of half a source period and is high for the rest. In oscillator half-cycles, with S = 1 + source bit and D = 2^gear, the high time is 2·S·D − S and the low time is S.
- R4: While the asynchronous reset is asserted, clk_out is held low.
- R5: After reset is released, the source bit is 1 and the gear code is 3. The first output period therefore lasts 16 oscillator cycles and starts at the first oscillator rising edge after release.
- R6: A setting written in the middle of an output period does not change that period. It is loaded at the next period boundary.
- R7: If several writes land within one output period, only the last one is loaded at the boundary.
- R8: With source bit 0 and gear code 0, clk_out follows the oscillator: high in its high half, low in its low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_in | input | 1 | Oscillator; all state updates on its rising edge |
| arst | input | 1 | Asynchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the pending setting |
| cfg_src | input | 1 | Source bit: 0 direct oscillator, 1 oscillator divided by two |
| cfg_gear | input | GEAR_W | Gear code; the divisor is 2^code |
| clk_out | output | 1 | Shaped internal clock |

## Verification
The bench builds the block with its default GEAR_W of 2. This puts all four gear codes under both source settings within reach, up to the longest period of 16 oscillator cycles. It also covers the reset setting at that longest period. At every half oscillator cycle the bench compares clk_out against a behavioural model. At every rising edge of clk_out it measures the high and low times of the period that just finished. This brings the half-cycle low phase of the direct source, writes that land mid-period, and back-to-back writes within one period into view.

// File: rtl/gear_div_pkg.sv
package gear_div_pkg;

    typedef enum logic [1:0] {
        PH_HIGH = 2'd0,
        PH_EDGE = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // Levels for one oscillator cycle: bit 1 = high half, bit 0 = low half
    function automatic logic [1:0] phase_levels(input phase_e ph);
        logic [1:0] lv;
        unique case (ph)
            PH_HIGH: lv = 2'b11;
            PH_EDGE: lv = 2'b10;
            PH_LOW:  lv = 2'b00;
            default: lv = 2'b00;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/gear_cfg_hold.sv
module gear_cfg_hold #(
    parameter int unsigned GEAR_W   = 2,
    parameter bit          RST_SRC  = 1'b1,
    parameter int unsigned RST_GEAR = 3
) (
    input  logic              clk,
    input  logic              arst,
    input  logic              we,
    input  logic              src_i,
    input  logic [GEAR_W-1:0] gear_i,
    output logic              src_o,
    output logic [GEAR_W-1:0] gear_o
);

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            src_o  <= RST_SRC;
            gear_o <= GEAR_W'(RST_GEAR);
        end else if (we) begin
            src_o  <= src_i;
            gear_o <= gear_i;
        end
    end

endmodule

// File: rtl/gear_phase_fsm.sv
module gear_phase_fsm
    import gear_div_pkg::*;
#(
    parameter int unsigned GEAR_W   = 2,
    parameter bit          RST_SRC  = 1'b1,
    parameter int unsigned RST_GEAR = 3,
    localparam int unsigned MAX_SH  = 1 << GEAR_W,
    localparam int unsigned MAX_CYC = 1 << MAX_SH,
    localparam int unsigned CNT_W   = $clog2(MAX_CYC),
    localparam int unsigned PW      = CNT_W + 1
) (
    input  logic              clk,
    input  logic              arst,
    input  logic              pend_src,
    input  logic [GEAR_W-1:0] pend_gear,
    output phase_e            phase,
    output logic [CNT_W-1:0]  rem,
    output logic              act_src,
    output logic [GEAR_W-1:0] act_gear
);

    phase_e             phase_d;
    logic [CNT_W-1:0]   rem_d;
    logic               src_d;
    logic [GEAR_W-1:0]  gear_d;
    logic [PW-1:0]      new_per;

    // Period in oscillator cycles of the pending setting
    always_comb begin
        new_per = PW'(1) << (int'(pend_gear) + int'(pend_src));
    end

    // State register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            phase    <= PH_LOW;
            rem      <= '0;
            act_src  <= RST_SRC;
            act_gear <= GEAR_W'(RST_GEAR);
        end else begin
            phase    <= phase_d;
            rem      <= rem_d;
            act_src  <= src_d;
            act_gear <= gear_d;
        end
    end

    // Transitions
    always_comb begin
        phase_d = phase;
        rem_d   = rem;
        src_d   = act_src;
        gear_d  = act_gear;
        unique case (phase)
            PH_HIGH: begin
                if (rem == '0) begin
                    phase_d = act_src ? PH_LOW : PH_EDGE;   // HIGH_TO_LOW / HIGH_TO_EDGE
                end else begin
                    rem_d = rem - CNT_W'(1);                  // HIGH_COUNT
                end
            end
            PH_EDGE, PH_LOW: begin
                src_d  = pend_src;
                gear_d = pend_gear;
                if (new_per == PW'(1)) begin
                    phase_d = PH_EDGE;                        // RELOAD_EDGE
                    rem_d   = '0;
                end else begin
                    phase_d = PH_HIGH;                        // RELOAD_HIGH
                    rem_d   = new_per[CNT_W-1:0] - CNT_W'(2);
                end
            end
            default: begin
                phase_d = PH_LOW;
                rem_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/gear_clk_shaper.sv
module gear_clk_shaper
    import gear_div_pkg::*;
(
    input  logic   osc_in,
    input  phase_e phase,
    output logic   clk_out
);

    logic [1:0] lv;

    // Output process: levels decoded from the state register
    always_comb begin
        lv = phase_levels(phase);
    end

    assign clk_out = osc_in ? lv[1] : lv[0];

endmodule

// File: rtl/gear_clk_divider.sv
module gear_clk_divider
    import gear_div_pkg::*;
#(
    parameter int unsigned GEAR_W   = 2,
    parameter bit          RST_SRC  = 1'b1,
    parameter int unsigned RST_GEAR = 3,
    localparam int unsigned CNT_W   = $clog2(1 << (1 << GEAR_W))
) (
    input  logic              osc_in,
    input  logic              arst,
    input  logic              cfg_we,
    input  logic              cfg_src,
    input  logic [GEAR_W-1:0] cfg_gear,
    output logic              clk_out
);

    logic              pend_src;
    logic [GEAR_W-1:0] pend_gear;
    phase_e            phase;
    logic [CNT_W-1:0]  rem;
    logic              act_src;
    logic [GEAR_W-1:0] act_gear;

    gear_cfg_hold #(
        .GEAR_W(GEAR_W), .RST_SRC(RST_SRC), .RST_GEAR(RST_GEAR)
    ) u_hold (
        .clk(osc_in), .arst(arst), .we(cfg_we),
        .src_i(cfg_src), .gear_i(cfg_gear),
        .src_o(pend_src), .gear_o(pend_gear)
    );

    gear_phase_fsm #(
        .GEAR_W(GEAR_W), .RST_SRC(RST_SRC), .RST_GEAR(RST_GEAR)
    ) u_fsm (
        .clk(osc_in), .arst(arst),
        .pend_src(pend_src), .pend_gear(pend_gear),
        .phase(phase), .rem(rem),
        .act_src(act_src), .act_gear(act_gear)
    );

    gear_clk_shaper u_shape (
        .osc_in(osc_in), .phase(phase), .clk_out(clk_out)
    );

endmodule

// File: rtl/gear_clk_divider_chk.sv
module gear_clk_divider_chk
    import gear_div_pkg::*;
#(
    parameter int unsigned GEAR_W = 2,
    parameter int unsigned CNT_W  = 4
) (
    input logic              osc_in,
    input logic              arst,
    input logic              clk_out,
    input logic              cfg_we,
    input logic              cfg_src,
    input logic [GEAR_W-1:0] cfg_gear,
    input logic              pend_src,
    input logic [GEAR_W-1:0] pend_gear,
    input phase_e            phase,
    input logic [CNT_W-1:0]  rem,
    input logic              act_src,
    input logic [GEAR_W-1:0] act_gear
);

    always_ff @(negedge osc_in) begin
        if (arst) begin
            assert_reset_low_R4: assert (clk_out == 1'b0)
                else $error("clk_out high during reset");
        end
    end

    assert_active_stable_R6: assert property (@(posedge osc_in) disable iff (arst)
        (phase == PH_HIGH) |=> ($stable(act_src) && $stable(act_gear)));

    assert_tail_match_R3: assert property (@(posedge osc_in) disable iff (arst)
        ((phase == PH_LOW) |-> act_src) and ((phase == PH_EDGE) |-> !act_src));

    assert_rem_bound_R1: assert property (@(posedge osc_in) disable iff (arst)
        (phase == PH_HIGH) |-> (int'(rem) + 2 <= (1 << (int'(act_gear) + int'(act_src)))));

    assert_last_write_R7: assert property (@(posedge osc_in) disable iff (arst)
        cfg_we |=> (pend_src == $past(cfg_src) && pend_gear == $past(cfg_gear)));

endmodule

bind gear_clk_divider gear_clk_divider_chk #(.GEAR_W(GEAR_W), .CNT_W(CNT_W)) u_chk (
    .osc_in(osc_in), .arst(arst), .clk_out(clk_out),
    .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_gear(cfg_gear),
    .pend_src(pend_src), .pend_gear(pend_gear),
    .phase(phase), .rem(rem), .act_src(act_src), .act_gear(act_gear)
);

// File: tb/gear_clk_divider_test.sv
module gear_clk_divider_test;

    logic       osc_in = 1'b0;
    logic       arst   = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_src = 1'b0;
    logic [1:0] cfg_gear = 2'd0;
    logic       clk_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;
    string tag = "R4";

    // behavioural model
    int m_pos, m_per, m_src, m_gear, p_src, p_gear, prv_src, prv_gear;
    int hi_run, lo_run;
    bit last_lv, skip_first;

    gear_clk_divider uut (
        .osc_in(osc_in), .arst(arst), .cfg_we(cfg_we),
        .cfg_src(cfg_src), .cfg_gear(cfg_gear), .clk_out(clk_out)
    );

    always #10 osc_in = ~osc_in;

    task automatic model_step();
        if (arst) begin
            m_src = 1; m_gear = 3; p_src = 1; p_gear = 3;
            m_per = 16; m_pos = 15;
            skip_first = 1; last_lv = 0; hi_run = 0; lo_run = 0;
        end else begin
            if (m_pos == m_per - 1) begin
                prv_src = m_src; prv_gear = m_gear;
                m_src = p_src; m_gear = p_gear;
                m_per = (1 + m_src) << m_gear;
                m_pos = 0;
            end else begin
                m_pos++;
            end
            if (cfg_we) begin
                p_src = int'(cfg_src); p_gear = int'(cfg_gear);
            end
        end
    endtask

    task automatic check_half(input bit first);
        bit exp;
        int s, d;
        if (first) exp = (m_pos < m_per - 1) || (m_src == 0);
        else       exp = (m_pos < m_per - 1);
        if (arst) exp = 0;
        n_vec++;
        if (clk_out !== exp) begin
            n_bad++;
            $display("FAIL %s: clk_out=%b expected %b at %0t", tag, clk_out, exp, $time);
        end
        if (!arst) begin
            if (clk_out === 1'b1 && last_lv == 1'b0) begin
                if (!skip_first) begin
                    s = 1 + prv_src; d = 1 << prv_gear;
                    n_vec++;
                    if (hi_run != 2*s*d - s || lo_run != s) begin
                        n_bad++;
                        $display("FAIL R3 (%s): high/low halves %0d/%0d expected %0d/%0d",
                                 tag, hi_run, lo_run, 2*s*d - s, s);
                    end
                end
                skip_first = 0; hi_run = 0; lo_run = 0;
            end
            if (clk_out === 1'b1) hi_run++; else lo_run++;
            last_lv = clk_out;
        end
    endtask

    task automatic tick();
        @(posedge osc_in);
        model_step();
        #5 check_half(1'b1);
        @(negedge osc_in);
        #5 check_half(1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_cfg(input bit s, input int g);
        cfg_we = 1'b1; cfg_src = s; cfg_gear = 2'(g);
        tick();
        cfg_we = 1'b0;
    endtask

    initial begin
        // R4: output low in reset
        tag = "R4";
        ticks(3);
        arst = 1'b0;
        // R5: reset setting, 16-cycle periods
        tag = "R5";
        ticks(40);
        // R1: gear sweep with halved source
        tag = "R1";
        for (int g = 0; g < 4; g++) begin
            write_cfg(1'b1, g);
            ticks(3 * (2 << g) + 20);
        end
        // R2: direct source
        tag = "R2";
        for (int g = 3; g >= 1; g--) begin
            write_cfg(1'b0, g);
            ticks(3 * (1 << g) + 20);
        end
        // R8: output follows oscillator
        tag = "R8";
        write_cfg(1'b0, 0);
        ticks(12);
        // R6: mid-period write keeps the running period
        tag = "R6";
        write_cfg(1'b1, 2);
        ticks(11);
        write_cfg(1'b0, 1);
        ticks(20);
        // R7: two writes in one period, last wins
        tag = "R7";
        write_cfg(1'b1, 3);
        ticks(20);
        write_cfg(1'b0, 3);
        ticks(2);
        write_cfg(1'b1, 1);
        ticks(40);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule